// File: doc/BRIEF.md
# Directory Coherence Controller

This block is the central directory for a group of private caches that share one backing memory. For every memory block it holds a presence bit per cache, a dirty flag, and a copy of each cache's line state. The line state is one of invalid, shared read-only, clean exclusive or dirty exclusive. A cache that misses, or that wants to write a line it does not own, sends one request. The controller then works out which caches must act on that request and issues them the needed commands in order. The commands are write back, invalidate and downgrade to shared. A final fill command tells the requester what rights it now holds.

Invalidations are filtered through the presence bits. A cache that holds no copy of the block never receives a command. On a miss, the requester names the line it will evict. If that line is dirty, the controller first orders a write back. Only one request is in flight at a time. A single-cycle done pulse marks the end of each request.

Top module: `coh_dir_ctrl`

## Requirements
- R1: After reset every line is invalid in every cache, `req_ready_o` is 1, and `cmd_valid_o` and `done_o` are 0.
- R2: A read by a cache that already holds the block in any valid state issues no command and ends with a `done_o` pulse.
- R3: On a miss with `req_vic_valid_i` set, the named victim line is dropped from the requester's directory entry before any peer command. If the victim line was dirty, a write back (cache = requester, block = victim) is issued first. If it was clean, it is dropped without a command. A victim the requester does not hold has no effect.
- R4: On a read miss where another cache holds the block dirty, that cache gets a write back and then a downgrade, and the requester is filled shared.
- R5: On a read miss where another cache holds the block clean exclusive, that cache gets a downgrade only. Caches holding shared copies receive nothing. The requester is filled shared.
- R6: A read miss with no other holder fills the requester clean exclusive.
- R7: A store by a cache holding a shared copy invalidates every other holder, in ascending cache order, and then fills the requester dirty.
- R8: A store by a cache holding the block clean exclusive or dirty issues no command, and the line becomes dirty.
- R9: On a store miss, a dirty holder gets a write back and then an invalidate. Every other holder gets an invalidate. The requester is then filled dirty.
- R10: Invalidate and downgrade commands go only to caches whose presence bit for that block is set.
- R11: Commands appear one per cycle while `req_ready_o` is 0, and `done_o` follows the last command. The command type codes are 0 invalidate, 1 write back, 2 downgrade and 3 fill. The grant codes on a fill are 1 shared, 2 clean exclusive and 3 dirty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle, request accepted |
| req_cache_i | input | CW | Requesting cache |
| req_block_i | input | BW | Requested block |
| req_store_i | input | 1 | 1 store, 0 read |
| req_vic_valid_i | input | 1 | A victim line is named |
| req_vic_block_i | input | BW | Victim block in the requester |
| cmd_valid_o | output | 1 | Command present this cycle |
| cmd_type_o | output | 2 | Command type code |
| cmd_cache_o | output | CW | Target cache |
| cmd_block_o | output | BW | Target block |
| cmd_grant_o | output | 2 | Granted state on a fill |
| done_o | output | 1 | Request finished |

## Verification
The bench builds the controller with four caches and four blocks. With that configuration it drives a directed sequence followed by several hundred pseudo-random requests from every cache, to every block, with and without victims. The small block count makes blocks collide constantly. As a result, every mix of shared, clean-exclusive and dirty holders arises at the moment another cache reads or stores. Each command list is compared against a directory model kept in the bench.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {ST_INV = 2'd0, ST_RO = 2'd1, ST_EX = 2'd2, ST_RW = 2'd3} line_state_e;
  typedef enum logic [1:0] {CMD_INV = 2'd0, CMD_WB = 2'd1, CMD_DOWN = 2'd2, CMD_FILL = 2'd3} cmd_e;
  typedef enum logic [2:0] {FS_IDLE, FS_VICT, FS_PEER, FS_FILL, FS_DONE} fsm_e;
endpackage

// File: rtl/coh_pick.sv
module coh_pick #(
  parameter int NC = 4,
  localparam int CW = $clog2(NC)
) (
  input  logic [NC-1:0] mask_i,
  output logic          any_o,
  output logic [CW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NC - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = CW'(i);
    end
  end
  assign any_o = |mask_i;
endmodule

// File: rtl/coh_dir_table.sv
module coh_dir_table
  import coh_pkg::*;
#(
  parameter int NC = 4,
  parameter int NB = 8,
  localparam int CW = $clog2(NC),
  localparam int BW = $clog2(NB)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [CW-1:0]                wr_cache_i,
  input  logic [BW-1:0]                wr_block_i,
  input  logic [1:0]                   wr_state_i,
  input  logic                         mod_we_i,
  input  logic                         mod_i,
  output logic [NB-1:0][NC-1:0][1:0]   state_o,
  output logic [NB-1:0][NC-1:0]        present_o,
  output logic [NB-1:0]                mod_o
);
  for (genvar gb = 0; gb < NB; gb++) begin : g_blk
    logic         mod_q;
    logic [NC-1:0] own_v;
    logic [NC-1:0] dirty_v;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mod_q <= 1'b0;
      else if (mod_we_i && wr_block_i == BW'(gb)) mod_q <= mod_i;
    end
    assign mod_o[gb] = mod_q;

    for (genvar gc = 0; gc < NC; gc++) begin : g_cache
      logic [1:0] st_q;
      logic       pres_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          st_q   <= ST_INV;
          pres_q <= 1'b0;
        end else if (we_i && wr_block_i == BW'(gb) && wr_cache_i == CW'(gc)) begin
          st_q   <= wr_state_i;
          pres_q <= (wr_state_i != ST_INV);
        end
      end
      assign state_o[gb][gc]   = st_q;
      assign present_o[gb][gc] = pres_q;
      assign own_v[gc]         = st_q[1];
      assign dirty_v[gc]       = &st_q;
    end

    // R9
    excl_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (own_v != '0) |-> ($countones(own_v) == 1 && $countones(present_o[gb]) == 1));
    // R4
    dirty_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mod_q |-> ($countones(dirty_v) == 1));
  end
endmodule

// File: rtl/coh_dir_fsm.sv
module coh_dir_fsm
  import coh_pkg::*;
#(
  parameter int NC = 4,
  parameter int NB = 8,
  localparam int CW = $clog2(NC),
  localparam int BW = $clog2(NB)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  output logic                       req_ready_o,
  input  logic [CW-1:0]              req_cache_i,
  input  logic [BW-1:0]              req_block_i,
  input  logic                       req_store_i,
  input  logic                       req_vic_valid_i,
  input  logic [BW-1:0]              req_vic_block_i,
  input  logic [NB-1:0][NC-1:0][1:0] state_i,
  input  logic [NB-1:0][NC-1:0]      present_i,
  input  logic [NB-1:0]              mod_i,
  input  logic                       pick_any_i,
  input  logic [CW-1:0]              pick_idx_i,
  output logic [NC-1:0]              pend_o,
  output logic                       tbl_we_o,
  output logic [CW-1:0]              tbl_cache_o,
  output logic [BW-1:0]              tbl_block_o,
  output logic [1:0]                 tbl_state_o,
  output logic                       mod_we_o,
  output logic                       mod_o,
  output logic                       cmd_valid_o,
  output logic [1:0]                 cmd_type_o,
  output logic [CW-1:0]              cmd_cache_o,
  output logic [BW-1:0]              cmd_block_o,
  output logic [1:0]                 cmd_grant_o,
  output logic                       done_o
);
  fsm_e          fs_q, fs_d;
  logic [CW-1:0] cache_q;
  logic [BW-1:0] block_q, vic_q;
  logic          store_q, vv_q, hit_q;
  logic [NC-1:0] pend_q, pend_d;
  logic [NC-1:0] others_m, owner_m;
  logic [1:0]    vic_st, own_st, peer_st, grant;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q    <= FS_IDLE;
      pend_q  <= '0;
      cache_q <= '0;
      block_q <= '0;
      vic_q   <= '0;
      store_q <= 1'b0;
      vv_q    <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      fs_q   <= fs_d;
      pend_q <= pend_d;
      if (fs_q == FS_IDLE && req_valid_i) begin
        cache_q <= req_cache_i;
        block_q <= req_block_i;
        vic_q   <= req_vic_block_i;
        store_q <= req_store_i;
        vv_q    <= req_vic_valid_i;
        hit_q   <= (state_i[req_block_i][req_cache_i] != ST_INV);
      end
    end
  end

  assign others_m = ~(NC'(1) << cache_q);
  for (genvar gc = 0; gc < NC; gc++) begin : g_own
    assign owner_m[gc] = state_i[block_q][gc][1];
  end
  assign vic_st  = state_i[vic_q][cache_q];
  assign own_st  = state_i[block_q][cache_q];
  assign peer_st = state_i[block_q][pick_idx_i];
  assign grant   = |(present_i[block_q] & others_m) ? ST_RO : ST_EX;
  assign pend_o  = pend_q;

  always_comb begin
    fs_d        = fs_q;
    pend_d      = pend_q;
    req_ready_o = 1'b0;
    done_o      = 1'b0;
    tbl_we_o    = 1'b0;
    tbl_cache_o = cache_q;
    tbl_block_o = block_q;
    tbl_state_o = ST_INV;
    mod_we_o    = 1'b0;
    mod_o       = 1'b0;
    cmd_valid_o = 1'b0;
    cmd_type_o  = CMD_INV;
    cmd_cache_o = cache_q;
    cmd_block_o = block_q;
    cmd_grant_o = ST_INV;
    unique case (fs_q)
      FS_IDLE: begin
        req_ready_o = 1'b1;
        if (req_valid_i) fs_d = FS_VICT;
      end
      FS_VICT: begin
        if (!hit_q && vv_q && vic_q != block_q && vic_st != ST_INV) begin
          tbl_we_o    = 1'b1;
          tbl_block_o = vic_q;
          mod_we_o    = 1'b1;
          if (vic_st == ST_RW) begin
            cmd_valid_o = 1'b1;
            cmd_type_o  = CMD_WB;
            cmd_block_o = vic_q;
          end
        end
        if (store_q)     pend_d = present_i[block_q] & others_m;
        else if (!hit_q) pend_d = owner_m & others_m;
        else             pend_d = '0;
        fs_d = FS_PEER;
      end
      FS_PEER: begin
        if (!pick_any_i) begin
          fs_d = FS_FILL;
        end else begin
          cmd_valid_o = 1'b1;
          cmd_cache_o = pick_idx_i;
          tbl_we_o    = 1'b1;
          tbl_cache_o = pick_idx_i;
          if (peer_st == ST_RW) begin
            // clean the owner first; it is handled again next cycle as EX
            cmd_type_o  = CMD_WB;
            tbl_state_o = ST_EX;
            mod_we_o    = 1'b1;
          end else begin
            pend_d[pick_idx_i] = 1'b0;
            cmd_type_o  = store_q ? CMD_INV : CMD_DOWN;
            tbl_state_o = store_q ? ST_INV : ST_RO;
          end
        end
      end
      FS_FILL: begin
        fs_d = FS_DONE;
        if (store_q) begin
          tbl_we_o    = 1'b1;
          tbl_state_o = ST_RW;
          mod_we_o    = 1'b1;
          mod_o       = 1'b1;
          if (!hit_q || own_st == ST_RO) begin
            cmd_valid_o = 1'b1;
            cmd_type_o  = CMD_FILL;
            cmd_grant_o = ST_RW;
          end
        end else if (!hit_q) begin
          tbl_we_o    = 1'b1;
          tbl_state_o = grant;
          mod_we_o    = 1'b1;
          cmd_valid_o = 1'b1;
          cmd_type_o  = CMD_FILL;
          cmd_grant_o = grant;
        end
      end
      FS_DONE: begin
        done_o = 1'b1;
        fs_d   = FS_IDLE;
      end
      default: fs_d = FS_IDLE;
    endcase
  end

  // R11
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (req_ready_o && !done_o));
  // R10
  inv_filter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_type_o != CMD_FILL && cmd_type_o != CMD_WB) |-> present_i[cmd_block_o][cmd_cache_o]);
  // R4
  wb_dirty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_type_o == CMD_WB) |-> mod_i[cmd_block_o]);
  // R7
  fill_present_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_type_o == CMD_FILL) |=> present_i[$past(cmd_block_o)][$past(cmd_cache_o)]);
endmodule

// File: rtl/coh_dir_ctrl.sv
module coh_dir_ctrl
  import coh_pkg::*;
#(
  parameter int NC = 4,
  parameter int NB = 8,
  localparam int CW = $clog2(NC),
  localparam int BW = $clog2(NB)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [CW-1:0] req_cache_i,
  input  logic [BW-1:0] req_block_i,
  input  logic          req_store_i,
  input  logic          req_vic_valid_i,
  input  logic [BW-1:0] req_vic_block_i,
  output logic          cmd_valid_o,
  output logic [1:0]    cmd_type_o,
  output logic [CW-1:0] cmd_cache_o,
  output logic [BW-1:0] cmd_block_o,
  output logic [1:0]    cmd_grant_o,
  output logic          done_o
);
  logic [NB-1:0][NC-1:0][1:0] state;
  logic [NB-1:0][NC-1:0]      present;
  logic [NB-1:0]              mod;
  logic                       tbl_we, mod_we, mod_wr, pick_any;
  logic [CW-1:0]              tbl_cache, pick_idx;
  logic [BW-1:0]              tbl_block;
  logic [1:0]                 tbl_state;
  logic [NC-1:0]              pend;

  coh_dir_table #(.NC(NC), .NB(NB)) u_table (
    .clk_i, .rst_ni,
    .we_i(tbl_we), .wr_cache_i(tbl_cache), .wr_block_i(tbl_block), .wr_state_i(tbl_state),
    .mod_we_i(mod_we), .mod_i(mod_wr),
    .state_o(state), .present_o(present), .mod_o(mod)
  );

  coh_pick #(.NC(NC)) u_pick (.mask_i(pend), .any_o(pick_any), .idx_o(pick_idx));

  coh_dir_fsm #(.NC(NC), .NB(NB)) u_fsm (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_cache_i, .req_block_i, .req_store_i,
    .req_vic_valid_i, .req_vic_block_i,
    .state_i(state), .present_i(present), .mod_i(mod),
    .pick_any_i(pick_any), .pick_idx_i(pick_idx), .pend_o(pend),
    .tbl_we_o(tbl_we), .tbl_cache_o(tbl_cache), .tbl_block_o(tbl_block), .tbl_state_o(tbl_state),
    .mod_we_o(mod_we), .mod_o(mod_wr),
    .cmd_valid_o, .cmd_type_o, .cmd_cache_o, .cmd_block_o, .cmd_grant_o, .done_o
  );
endmodule

// File: tb/tb_coh_dir_ctrl.sv
`timescale 1ns/1ps
module tb_coh_dir_ctrl;
  localparam int NC = 4;
  localparam int NB = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_store = 1'b0, vic_valid = 1'b0;
  logic [1:0] req_cache = '0, req_block = '0, vic_block = '0;
  logic req_ready, cmd_valid, done;
  logic [1:0] cmd_type, cmd_cache, cmd_block, cmd_grant;

  coh_dir_ctrl #(.NC(NC), .NB(NB)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_cache_i(req_cache), .req_block_i(req_block), .req_store_i(req_store),
    .req_vic_valid_i(vic_valid), .req_vic_block_i(vic_block),
    .cmd_valid_o(cmd_valid), .cmd_type_o(cmd_type), .cmd_cache_o(cmd_cache),
    .cmd_block_o(cmd_block), .cmd_grant_o(cmd_grant), .done_o(done)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int mst[NB][NC];
  int mmod[NB];
  int et[16], ec[16], eb[16], eg[16];
  int ne;
  int at[16], ac[16], ab[16], ag[16];
  int ng;

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  function automatic void push(input int t, input int c, input int b, input int g);
    et[ne] = t; ec[ne] = c; eb[ne] = b; eg[ne] = g;
    ne++;
  endfunction

  task automatic do_req(input int c, input int b, input int s, input int vv, input int v);
    int pre[NB][NC];
    bit hit, had_rw, had_ex, others, vwb, busy_bad, seen;
    int own;
    string tag;
    pre = mst;
    ne = 0; had_rw = 0; had_ex = 0; others = 0; vwb = 0;
    hit = (mst[b][c] != 0);
    own = mst[b][c];
    if (!hit && vv != 0 && v != b && mst[v][c] != 0) begin
      if (mst[v][c] == 3) begin push(1, c, v, 0); vwb = 1; end
      mst[v][c] = 0; mmod[v] = 0;
    end
    if (s == 0) begin
      if (!hit) begin
        for (int r = 0; r < NC; r++) begin
          if (r == c) continue;
          if (mst[b][r] == 3) begin push(1, r, b, 0); mmod[b] = 0; mst[b][r] = 2; had_rw = 1; end
          if (mst[b][r] == 2) begin push(2, r, b, 0); mst[b][r] = 1; had_ex = 1; end
          if (mst[b][r] != 0) others = 1;
        end
        push(3, c, b, others ? 1 : 2);
        mst[b][c] = others ? 1 : 2;
      end
    end else begin
      for (int r = 0; r < NC; r++) begin
        if (r == c || mst[b][r] == 0) continue;
        if (mst[b][r] == 3) begin push(1, r, b, 0); mmod[b] = 0; end
        push(0, r, b, 0);
        mst[b][r] = 0;
      end
      if (!hit || own == 1) push(3, c, b, 3);
      mst[b][c] = 3; mmod[b] = 1;
    end
    if (vwb) tag = "R3";
    else if (s == 0) tag = hit ? "R2" : had_rw ? "R4" : others ? "R5" : "R6";
    else tag = !hit ? "R9" : (own == 1) ? "R7" : "R8";

    @(negedge clk);
    req_valid = 1'b1; req_cache = 2'(c); req_block = 2'(b); req_store = (s != 0);
    vic_valid = (vv != 0); vic_block = 2'(v);
    @(negedge clk);
    req_valid = 1'b0;
    ng = 0; busy_bad = 0; seen = 0;
    for (int k = 0; k < 64; k++) begin
      if (req_ready) busy_bad = 1;
      if (cmd_valid && ng < 16) begin
        at[ng] = int'(cmd_type); ac[ng] = int'(cmd_cache); ab[ng] = int'(cmd_block); ag[ng] = int'(cmd_grant);
        ng++;
      end
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
    check(seen && !busy_bad, "R11", "done seen with ready low", int'(seen && !busy_bad), 1);
    check(ng == ne, tag, "command count", ng, ne);
    for (int i = 0; i < ng && i < ne; i++) begin
      check(at[i] == et[i], tag, "command type", at[i], et[i]);
      check(ac[i] == ec[i], tag, "command cache", ac[i], ec[i]);
      check(ab[i] == eb[i], tag, "command block", ab[i], eb[i]);
      if (et[i] == 3) check(ag[i] == eg[i], tag, "fill grant", ag[i], eg[i]);
    end
    for (int i = 0; i < ng; i++) begin
      if (at[i] == 0 || at[i] == 2)
        check(pre[ab[i]][ac[i]] != 0, "R10", "target held block", 0, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R11 watchdog expired act=0 exp=1");
    report();
  end

  initial begin
    logic [15:0] lfsr;
    for (int b = 0; b < NB; b++) begin
      mmod[b] = 0;
      for (int c = 0; c < NC; c++) mst[b][c] = 0;
    end
    repeat (3) @(negedge clk);
    check(req_ready === 1'b1, "R1", "ready in reset", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b1 && cmd_valid === 1'b0 && done === 1'b0, "R1", "idle outputs", int'(cmd_valid), 0);

    do_req(0, 0, 0, 0, 0);  // R6 fill EX
    do_req(0, 0, 0, 0, 0);  // R2 hit
    do_req(0, 0, 1, 0, 0);  // R8 EX to RW silently
    do_req(1, 0, 0, 0, 0);  // R4 wb + down + fill RO
    do_req(2, 0, 0, 0, 0);  // R5 RO holders only
    do_req(1, 0, 1, 0, 0);  // R7 inv 0 and 2, fill RW
    do_req(3, 1, 0, 0, 0);  // R6
    do_req(2, 1, 1, 0, 0);  // R9 inv 3
    do_req(0, 1, 1, 0, 0);  // R9 wb + inv 2
    do_req(3, 1, 0, 0, 0);  // R4
    do_req(0, 2, 0, 1, 1);  // R3 victim block 1 is RO in cache 0: dropped silently
    do_req(1, 1, 1, 0, 0);  // R10 cache 0 must not be invalidated
    do_req(1, 3, 0, 1, 1);  // R3 dirty victim written back
    do_req(2, 3, 0, 1, 0);  // R3 victim not held: no effect
    do_req(0, 3, 1, 0, 0);  // R7/R9 mix

    lfsr = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      for (int k = 0; k < 8; k++) lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      do_req(int'(lfsr[1:0]), int'(lfsr[3:2]), int'(lfsr[4] & lfsr[8]), int'(lfsr[5]), int'(lfsr[7:6]));
    end
    report();
  end
endmodule